// File: doc/BRIEF.md
# Front-End Control Register Bank with Reset Sequencer

This block keeps the control state of a multi-channel converter front end: a mode bit that chooses between configuration (program) mode and data mode, a self-clearing software reset bit, and a power register. The power register's lowest bit forces every section on. Each other bit enables one section. A small write port (address, data, strobe) loads the registers. Every register is visible on a flat output bus. The mode flag and the resolved per-section power enables come out as separate pins.

The active-low reset pin and the software reset bit start the same fixed-length reset phase. During that phase every register is cleared and writes are dropped. A long counted delay follows the reset phase. After the delay, a level output tells the framing logic that it may issue its first frame sync. That output stays high until the next reset of either kind. The pin is asserted asynchronously and released through a synchronizer. The pin release therefore reaches the sequencer two edges late.

Top module: `fe_ctrl_seq`

## Requirements
- R1: While `rst_n` is low, every register reads zero, `rst_busy_o` is 1, and `fs_ready_o`, `data_mode_o` and every bit of `pwr_en_o` are 0. This holds from the moment of assertion, with no clock edge needed.
- R2: After `rst_n` rises, `rst_busy_o` falls on the sixth rising clock edge. That count is the two synchronizer stages plus the four-cycle reset phase.
- R3: A write of data with bit 7 set to address 0 (control register) clears every register on the same edge. It then holds `rst_busy_o` high for exactly four clock cycles.
- R4: Bit 7 of the control register always reads back 0.
- R5: A write strobed in any cycle where `rst_busy_o` is high is dropped. This includes the last busy cycle.
- R6: `fs_ready_o` rises on the 2070th rising edge after the edge on which `rst_busy_o` falls. It is never high while busy, and it stays high until the next reset.
- R7: A software reset issued during the delay drops `fs_ready_o` progress. The full reset phase and the full 2070-cycle delay are then counted again.
- R8: A write outside a busy phase stores `wr_data` in register `wr_addr`. The value appears on `regs_o[8*wr_addr +: 8]` after that edge, and no other register changes.
- R9: `data_mode_o` equals bit 0 of the control register (0 = program mode, 1 = data mode). It changes only when the control register is written or reset.
- R10: The power register sits at address 2. `pwr_en_o[i]` equals power-register bit i+1 OR bit 0 (the global override). Bit 5 enables the reference, which comes out on `pwr_en_o[4]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 8 | Write data |
| regs_o | output | 64 | All eight registers, register i at bits 8i+7..8i |
| data_mode_o | output | 1 | 1 = data mode, 0 = program mode |
| pwr_en_o | output | 7 | Resolved enable of each power section |
| rst_busy_o | output | 1 | Reset phase in progress |
| fs_ready_o | output | 1 | First frame sync may be issued |

## Verification
Two things can fall in the same cycle: the end of the reset phase and an incoming register write. The bench strobes a write in every cycle while `rst_busy_o` is seen high, so the final busy cycle carries a write. The registers must then still read zero, and a write strobed in the very next cycle must land. A second overlap is a software reset arriving in the middle of the post-reset delay. There the bench checks that the delay restarts from zero and that the measured wait again equals the full count.

// File: rtl/fe_ctrl_pkg.sv
package fe_ctrl_pkg;
  typedef enum logic [1:0] {
    SEQ_RST  = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fe_rst_sync.sv
module fe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fe_seq.sv
module fe_seq
  import fe_ctrl_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int FS_DLY  = 2070
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst_i,
  output logic busy_o,
  output logic fs_ready_o
);
  localparam int MAXC = (FS_DLY > RST_CYC) ? FS_DLY : RST_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_RST: begin
        if (cnt_q == CW'(RST_CYC - 1)) begin
          state_d = SEQ_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (cnt_q == CW'(FS_DLY - 1)) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = SEQ_RUN;
        cnt_d   = '0;
      end
    endcase
    if (sw_rst_i) begin
      state_d = SEQ_RST;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RST;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o     = (state_q == SEQ_RST);
  assign fs_ready_o = (state_q == SEQ_RUN);

  // R6
  no_fs_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !fs_ready_o);
  // R3
  swrst_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> busy_o);
  // R6
  fs_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_ready_o) |-> $past(state_q == SEQ_WAIT));
endmodule

// File: rtl/fe_regs.sv
module fe_regs #(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int CTRL_ADDR = 0,
  parameter int SRST_BIT  = 7,
  parameter int MODE_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [(2**AW)*DW-1:0] regs_o,
  output logic             sw_rst_o,
  output logic             mode_o
);
  localparam int          NREG      = 2**AW;
  localparam logic [DW-1:0] CTRL_MASK = ~(DW'(1) << SRST_BIT);

  logic          wr_fire;
  logic          ctrl_hit;
  logic [DW-1:0] regs_q [NREG];

  assign wr_fire  = wr_en & ~busy_i;
  assign ctrl_hit = wr_fire & (wr_addr == AW'(CTRL_ADDR));
  assign sw_rst_o = ctrl_hit & wr_data[SRST_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          hit;
    logic          en;
    logic [DW-1:0] wval;
    logic [DW-1:0] nxt;

    assign hit = wr_fire & (wr_addr == AW'(i));
    if (i == CTRL_ADDR) begin : g_ctrl
      assign wval = wr_data & CTRL_MASK;
    end else begin : g_plain
      assign wval = wr_data;
    end

    assign en  = sw_rst_o | hit;
    assign nxt = sw_rst_o ? '0 : wval;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[i] <= '0;
      else if (en) regs_q[i] <= nxt;
    end

    assign regs_o[i*DW +: DW] = regs_q[i];
  end

  assign mode_o = regs_q[CTRL_ADDR][MODE_BIT];

  // R5
  no_wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(regs_o));
  // R3
  swrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_o |=> (regs_o == '0));
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_hit |=> $stable(mode_o));
  // R4
  srst_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> !regs_o[CTRL_ADDR*DW + SRST_BIT]);
endmodule

// File: rtl/fe_pwr_map.sv
module fe_pwr_map #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pwr_reg_i,
  output logic [DW-2:0] pwr_en_o
);
  localparam int NSEC = DW - 1;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    assign pwr_en_o[s] = pwr_reg_i[s+1] | pwr_reg_i[0];
  end

  // R10
  glb_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_reg_i[0] |-> (pwr_en_o == {NSEC{1'b1}}));
  // R10
  no_spurious_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_reg_i == '0) |-> (pwr_en_o == '0));
endmodule

// File: rtl/fe_ctrl_seq.sv
module fe_ctrl_seq #(
  parameter int AW         = 3,
  parameter int DW         = 8,
  parameter int CTRL_ADDR  = 0,
  parameter int PWR_ADDR   = 2,
  parameter int SRST_BIT   = 7,
  parameter int MODE_BIT   = 0,
  parameter int SYNC_STG   = 2,
  parameter int RST_CYC    = 4,
  parameter int FS_DLY     = 2070
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  output logic [(2**AW)*DW-1:0] regs_o,
  output logic                  data_mode_o,
  output logic [DW-2:0]         pwr_en_o,
  output logic                  rst_busy_o,
  output logic                  fs_ready_o
);
  logic arst_n;
  logic sw_rst;
  logic busy;

  fe_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(arst_n)
  );

  fe_seq #(.RST_CYC(RST_CYC), .FS_DLY(FS_DLY)) u_seq (
    .clk       (clk),
    .rst_n     (arst_n),
    .sw_rst_i  (sw_rst),
    .busy_o    (busy),
    .fs_ready_o(fs_ready_o)
  );

  fe_regs #(
    .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
    .SRST_BIT(SRST_BIT), .MODE_BIT(MODE_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (arst_n),
    .busy_i  (busy),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_o  (regs_o),
    .sw_rst_o(sw_rst),
    .mode_o  (data_mode_o)
  );

  fe_pwr_map #(.DW(DW)) u_pwr (
    .clk      (clk),
    .rst_n    (arst_n),
    .pwr_reg_i(regs_o[PWR_ADDR*DW +: DW]),
    .pwr_en_o (pwr_en_o)
  );

  assign rst_busy_o = busy;
endmodule

// File: tb/fe_ctrl_seq_tb.sv
module fe_ctrl_seq_tb;
  localparam int FS_DLY = 2070;
  localparam int RST_CYC = 4;
  localparam int SYNC_STG = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [63:0] regs_o;
  logic        data_mode_o;
  logic [6:0]  pwr_en_o;
  logic        rst_busy_o;
  logic        fs_ready_o;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  fe_ctrl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_o(regs_o), .data_mode_o(data_mode_o),
    .pwr_en_o(pwr_en_o), .rst_busy_o(rst_busy_o), .fs_ready_o(fs_ready_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts sampled busy cycles, driving a write into every one of them
  task automatic busy_len(output int n);
    n = 0;
    while (rst_busy_o) begin
      n++;
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'hFF;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic fs_wait(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k > FS_DLY + 10) break;
    end while (!fs_ready_o);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, k;
    logic [7:0] v;
    logic [6:0] e;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    clear_model();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 regs", regs_o, 64'h0);
    check("R1 busy", rst_busy_o, 1);
    check("R1 fs", fs_ready_o, 0);
    check("R1 pwr", pwr_en_o, 0);
    check("R1 mode", data_mode_o, 0);

    // R2 release timing
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (rst_busy_o && n < 20);
    check("R2 release edges", n, SYNC_STG + RST_CYC);

    // R6 delay after pin reset
    fs_wait(k);
    check("R6 delay after pin", k, FS_DLY);

    // R8 write/readback sweep, all addresses except the control register
    for (int a = 1; a < 8; a++) begin
      for (int p = 0; p < 4; p++) begin
        v = 8'((a * 53 + p * 97 + 11) & 8'hFF);
        do_write(3'(a), v);
        model[a] = v;
        check("R8 readback", regs_o, model_flat());
      end
    end

    // R10 exhaustive power register sweep
    for (int x = 0; x < 256; x++) begin
      v = 8'(x);
      do_write(3'd2, v);
      model[2] = v;
      for (int s = 0; s < 7; s++) e[s] = v[s+1] | v[0];
      check("R10 pwr_en", pwr_en_o, e);
      if (x == 32 || x == 1 || x == 0) check("R10 ref", pwr_en_o[4], v[5] | v[0]);
    end

    // R9 mode, R4 bit 7 masked
    do_write(3'd0, 8'h01);
    check("R9 data mode", data_mode_o, 1);
    do_write(3'd1, 8'h5A);
    model[1] = 8'h5A;
    check("R9 mode held", data_mode_o, 1);
    do_write(3'd0, 8'h7E);
    check("R9 program mode", data_mode_o, 0);
    check("R4 ctrl readback", regs_o[7:0], 8'h7E);
    model[0] = 8'h7E;
    check("R6 fs held high", fs_ready_o, 1);

    // R3 software reset, R5 writes during every busy cycle incl. the last
    do_write(3'd0, 8'h81);
    check("R3 regs cleared", regs_o, 64'h0);
    check("R4 bit7 zero", regs_o[7], 0);
    check("R6 fs dropped", fs_ready_o, 0);
    busy_len(n);
    check("R3 busy length", n, RST_CYC);
    check("R5 writes dropped", regs_o, 64'h0);
    check("R5 pwr still off", pwr_en_o, 0);
    clear_model();
    do_write(3'd2, 8'h21);
    model[2] = 8'h21;
    check("R5 first write after busy", regs_o, model_flat());

    // R7 software reset in the middle of the delay
    repeat (500) @(negedge clk);
    check("R7 still waiting", fs_ready_o, 0);
    do_write(3'd0, 8'h80);
    check("R7 busy again", rst_busy_o, 1);
    busy_len(n);
    check("R7 busy length", n, RST_CYC);
    fs_wait(k);
    check("R7 full delay recounted", k, FS_DLY);
    n = 0;
    for (int c = 0; c < 50; c++) begin @(negedge clk); if (!fs_ready_o) n++; end
    check("R6 fs stays high", n, 0);

    // R1 asynchronous assertion mid-run
    do_write(3'd3, 8'hC3);
    #2 rst_n = 1'b0;
    #1;
    check("R1 async clear", regs_o, 64'h0);
    check("R1 async busy", rst_busy_o, 1);
    check("R1 async fs", fs_ready_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule